// File: doc/BRIEF.md
# Host Sequential Access Pointer Controller

This block gives a host port sequential access to the function memory of a waveform generator. The memory holds 16-bit words behind a 17-bit address. The host never sends a full address. A set-pointer command loads the upper 16 bits and picks one of six access modes. Each mode pairs a direction (read or write) with an LSB policy. The LSB can toggle, so a 32-bit value is stored as a low word and a high word. It can also be held at 0 or at 1, so one 16-bit channel of an interleaved pair is reached. After the pointer is set, a string of data commands moves through memory with no further addressing.

Reads are prefetched. A set-pointer command in a read mode fetches the first word into a host data register. Each data-read command then returns the word that register held, fetches the next word into it and advances the pointer. Writes store the command word at the pointer and then advance it.

The memory is shared with the playout engine, which must never wait. Each cycle in which playout asks for memory, playout gets it. A host access takes the next cycle without a playout request. The host port stalls until its access has completed and a one-cycle completion pulse has been given.

Top module: `fg_host_ptr_ctrl`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, `cmd_done_o` is 0, no host memory access is made, and the host data register holds 0.
- R2: A set-pointer command (op 0) is accepted only for sub-addresses 0 and 3 when `dual_mode_i` is 0, and only for 1, 2, 4 and 5 when it is 1. A rejected command, or op 3, finishes in the cycle after acceptance with `cmd_ok_o`=0. It makes no memory access and changes neither the pointer, the mode nor the host register.
- R3: Sub-address 0 (32-bit read) loads the upper 16 bits from `cmd_data_i` with LSB 0, and the pointer then toggles. Every host access adds one to the full 17-bit pointer.
- R4: Sub-addresses 1 and 2 (channel reads) hold the LSB at 0 and 1 respectively. Each host access adds one to the upper 16 bits only.
- R5: A set-pointer command in a read mode reads the memory at the new pointer into the host data register. A data-read (op 1) returns on `cmd_rdata_o` the value the register held when the command was accepted. It then reads the next word into the register.
- R6: Sub-addresses 3, 4 and 5 (writes) load the pointer with LSB 0 (toggling), 0 (held) and 1 (held) respectively. They make no memory access and finish in the cycle after acceptance with `cmd_ok_o`=1.
- R7: A data-write (op 2) writes `cmd_data_i` to memory at the current pointer and then advances the pointer according to the current mode.
- R8: While `play_req_i` is 1, the memory port performs a read at `play_addr_i` in that same cycle, and `play_grant_o` is 1. A host access occurs only in a cycle without a playout request.
- R9: `cmd_ready_o` is 0 from the cycle after acceptance until `cmd_done_o` has pulsed for exactly one cycle. `cmd_done_o` rises in the cycle after the host access completes: after the write cycle for a write, and after the read data has been captured for a read.
- R10: Before any set-pointer command, data commands use pointer 0 in 32-bit toggling mode.
- R11: The pointer wraps. In toggling mode it goes from 0x1FFFF to 0x00000. In held mode the upper 16 bits go from 0xFFFF to 0x0000 and the LSB is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dual_mode_i | input | 1 | 0: single 32-bit function, 1: two 16-bit channels |
| cmd_valid_i | input | 1 | Host command present |
| cmd_op_i | input | 2 | 0 set-pointer, 1 data-read, 2 data-write, 3 none |
| cmd_sub_i | input | 3 | Set-pointer sub-address |
| cmd_data_i | input | 16 | Upper pointer bits or write word |
| cmd_ready_o | output | 1 | Host command may be accepted |
| cmd_done_o | output | 1 | One-cycle completion pulse |
| cmd_ok_o | output | 1 | Command accepted as legal (valid with done) |
| cmd_rdata_o | output | 16 | Data-read result (valid with done) |
| play_req_i | input | 1 | Playout memory request |
| play_addr_i | input | 17 | Playout read address |
| play_grant_o | output | 1 | Playout owns the memory this cycle |
| mem_en_o | output | 1 | Memory cycle enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 17 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after enable |

## Verification
A wrong pointer or mode shows at the memory port on the very next host access, as an address that differs from the one the bench expects. The bench checks the address of every host access. A broken prefetch register shows one command later, when a data-read returns a word other than the one fetched before it. Arbitration faults show in the same cycle: a host access that overlaps a playout request, or a playout request that finds the memory given to someone else.

// File: rtl/fg_host_pkg.sv
package fg_host_pkg;
  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_NONE = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAP  = 2'd2,
    ST_RESP = 2'd3
  } host_st_e;

  typedef struct packed {
    logic legal;
    logic is_read;
    logic toggle;
    logic lsb;
  } set_dec_t;
endpackage

// File: rtl/fg_host_decode.sv
module fg_host_decode
  import fg_host_pkg::*;
#(
  parameter int SUB_W = 3
) (
  input  logic [SUB_W-1:0] sub_i,
  input  logic             dual_mode_i,
  output set_dec_t         dec_o
);
  logic is_32, is_dual;

  always_comb begin
    is_32   = (sub_i == SUB_W'(0)) || (sub_i == SUB_W'(3));
    is_dual = (sub_i == SUB_W'(1)) || (sub_i == SUB_W'(2)) ||
              (sub_i == SUB_W'(4)) || (sub_i == SUB_W'(5));
    dec_o.legal   = dual_mode_i ? is_dual : is_32;
    dec_o.is_read = sub_i < SUB_W'(3);
    dec_o.toggle  = is_32;
    dec_o.lsb     = (sub_i == SUB_W'(2)) || (sub_i == SUB_W'(5));
  end
endmodule

// File: rtl/fg_host_pointer.sv
module fg_host_pointer #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-2:0] load_upper_i,
  input  logic              load_lsb_i,
  input  logic              load_toggle_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int UPPER_W = ADDR_W - 1;

  logic [ADDR_W-1:0] ptr_q;
  logic              toggle_q;
  logic [ADDR_W-1:0] ptr_next;

  always_comb begin
    if (toggle_q) ptr_next = ptr_q + ADDR_W'(1);
    else          ptr_next = {ptr_q[ADDR_W-1:1] + UPPER_W'(1), ptr_q[0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      toggle_q <= 1'b1;
    end else if (load_i) begin
      ptr_q    <= {load_upper_i, load_lsb_i};
      toggle_q <= load_toggle_i;
    end else if (adv_i) begin
      ptr_q    <= ptr_next;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/fg_mem_arbiter.sv
module fg_mem_arbiter #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              play_req_i,
  input  logic [ADDR_W-1:0] play_addr_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              play_grant_o,
  output logic              host_grant_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  always_comb begin
    play_grant_o = play_req_i;
    host_grant_o = host_req_i && !play_req_i;
    mem_en_o     = play_req_i || host_req_i;
    mem_we_o     = host_grant_o && host_we_i;
    mem_addr_o   = play_req_i ? play_addr_i : host_addr_i;
    mem_wdata_o  = host_wdata_i;
  end
endmodule

// File: rtl/fg_host_ptr_ctrl.sv
module fg_host_ptr_ctrl
  import fg_host_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int SUB_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dual_mode_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [SUB_W-1:0]  cmd_sub_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              cmd_ready_o,
  output logic              cmd_done_o,
  output logic              cmd_ok_o,
  output logic [DATA_W-1:0] cmd_rdata_o,
  input  logic              play_req_i,
  input  logic [ADDR_W-1:0] play_addr_i,
  output logic              play_grant_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int UPPER_W = ADDR_W - 1;

  host_st_e          st_q;
  host_op_e          op;
  set_dec_t          dec;
  logic              accept;
  logic              we_q;
  logic              ok_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] hreg_q;
  logic [DATA_W-1:0] resp_q;
  logic              ptr_load;
  logic              ptr_adv;
  logic [ADDR_W-1:0] ptr;
  logic              host_req;
  logic              host_grant;

  assign op     = host_op_e'(cmd_op_i);
  assign accept = cmd_valid_i && (st_q == ST_IDLE);

  fg_host_decode #(.SUB_W(SUB_W)) u_decode (
    .sub_i       (cmd_sub_i),
    .dual_mode_i (dual_mode_i),
    .dec_o       (dec)
  );

  assign ptr_load = accept && (op == OP_SET) && dec.legal;
  assign ptr_adv  = ((st_q == ST_WAIT) && host_grant && we_q) || (st_q == ST_CAP);

  fg_host_pointer #(.ADDR_W(ADDR_W)) u_pointer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (ptr_load),
    .load_upper_i  (cmd_data_i[UPPER_W-1:0]),
    .load_lsb_i    (dec.lsb),
    .load_toggle_i (dec.toggle),
    .adv_i         (ptr_adv),
    .ptr_o         (ptr)
  );

  assign host_req = (st_q == ST_WAIT);

  fg_mem_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .play_req_i   (play_req_i),
    .play_addr_i  (play_addr_i),
    .host_req_i   (host_req),
    .host_we_i    (we_q),
    .host_addr_i  (ptr),
    .host_wdata_i (wdata_q),
    .play_grant_o (play_grant_o),
    .host_grant_o (host_grant),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      ok_q    <= 1'b0;
      wdata_q <= '0;
      hreg_q  <= '0;
      resp_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          resp_q <= '0;
          ok_q   <= 1'b1;
          unique case (op)
            OP_SET: begin
              we_q <= 1'b0;
              if (!dec.legal)       begin ok_q <= 1'b0; st_q <= ST_RESP; end
              else if (dec.is_read) st_q <= ST_WAIT;
              else                  st_q <= ST_RESP;
            end
            OP_RD: begin
              we_q   <= 1'b0;
              resp_q <= hreg_q;
              st_q   <= ST_WAIT;
            end
            OP_WR: begin
              we_q    <= 1'b1;
              wdata_q <= cmd_data_i;
              st_q    <= ST_WAIT;
            end
            default: begin
              ok_q <= 1'b0;
              st_q <= ST_RESP;
            end
          endcase
        end
        ST_WAIT: if (host_grant) st_q <= we_q ? ST_RESP : ST_CAP;
        ST_CAP: begin
          hreg_q <= mem_rdata_i;
          st_q   <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign cmd_done_o  = (st_q == ST_RESP);
  assign cmd_ok_o    = cmd_done_o && ok_q;
  assign cmd_rdata_o = resp_q;
endmodule

// File: rtl/fg_host_ptr_ctrl_chk.sv
module fg_host_ptr_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int SUB_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dual_mode_i,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [SUB_W-1:0]  cmd_sub_i,
  input logic              cmd_ready_o,
  input logic              cmd_done_o,
  input logic              cmd_ok_o,
  input logic              play_req_i,
  input logic [ADDR_W-1:0] play_addr_i,
  input logic              play_grant_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic set_acc, sub_32, sub_dual, set_bad, set_wr_ok;

  always_comb begin
    set_acc   = cmd_valid_i && cmd_ready_o && (cmd_op_i == 2'd0);
    sub_32    = (cmd_sub_i == SUB_W'(0)) || (cmd_sub_i == SUB_W'(3));
    sub_dual  = (cmd_sub_i == SUB_W'(1)) || (cmd_sub_i == SUB_W'(2)) ||
                (cmd_sub_i == SUB_W'(4)) || (cmd_sub_i == SUB_W'(5));
    set_bad   = set_acc && (dual_mode_i ? !sub_dual : !sub_32);
    set_wr_ok = set_acc && !set_bad && (cmd_sub_i >= SUB_W'(3));
  end

  p_reject_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_bad |=> cmd_done_o && !cmd_ok_o);

  p_set_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr_ok |=> cmd_done_o && cmd_ok_o);

  p_play_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_req_i |-> play_grant_o && mem_en_o && !mem_we_o && (mem_addr_o == play_addr_i));

  p_host_yields_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !play_req_i);

  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |-> !cmd_ready_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_o |=> !cmd_done_o && cmd_ready_o);
endmodule

bind fg_host_ptr_ctrl fg_host_ptr_ctrl_chk #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dual_mode_i  (dual_mode_i),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .cmd_sub_i    (cmd_sub_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_done_o   (cmd_done_o),
  .cmd_ok_o     (cmd_ok_o),
  .play_req_i   (play_req_i),
  .play_addr_i  (play_addr_i),
  .play_grant_o (play_grant_o),
  .mem_en_o     (mem_en_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o)
);

// File: tb/fg_host_ptr_ctrl_test.sv
module fg_host_ptr_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dual_mode_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'd3;
  logic [2:0]  cmd_sub_i = 3'd0;
  logic [15:0] cmd_data_i = 16'd0;
  logic        cmd_ready_o, cmd_done_o, cmd_ok_o;
  logic [15:0] cmd_rdata_o;
  logic        play_req_i = 1'b0;
  logic [16:0] play_addr_i = 17'd0;
  logic        play_grant_o, mem_en_o, mem_we_o;
  logic [16:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = 16'd0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [15:0] mem_q   [int];
  logic [15:0] exp_mem [int];
  logic [16:0] m_ptr = 17'd0;
  logic        m_tog = 1'b1;
  logic [15:0] m_hreg = 16'd0;

  always #5 clk_i = ~clk_i;

  fg_host_ptr_ctrl uut (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (mem_en_o) begin
      mem_rdata_i <= mem_q.exists(int'(mem_addr_o)) ? mem_q[int'(mem_addr_o)] : 16'd0;
      if (mem_we_o) mem_q[int'(mem_addr_o)] = mem_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal_set(input bit dual, input int sub);
    return dual ? (sub == 1 || sub == 2 || sub == 4 || sub == 5) : (sub == 0 || sub == 3);
  endfunction

  function automatic logic [16:0] adv(input logic [16:0] p, input logic tog);
    return tog ? p + 17'd1 : {p[16:1] + 16'd1, p[0]};
  endfunction

  // op: 0 set, 1 read, 2 write, 3 none
  task automatic run_cmd(input int op, input int sub, input logic [15:0] data,
                         input int hold, input int pct);
    int exp_acc = 0;
    logic exp_we = 1'b0;
    logic exp_ok = 1'b1;
    logic [15:0] exp_rd = 16'd0;
    int nacc = 0;
    int cyc = 0;
    if (op == 0) begin
      if (legal_set(dual_mode_i, sub)) begin
        m_ptr = {data, (sub == 2 || sub == 5)};
        m_tog = (sub == 0 || sub == 3);
        exp_acc = (sub < 3) ? 1 : 0;
      end else exp_ok = 1'b0;
    end else if (op == 1) begin
      exp_acc = 1; exp_rd = m_hreg;
    end else if (op == 2) begin
      exp_acc = 1; exp_we = 1'b1;
    end else exp_ok = 1'b0;

    @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R9", "ready before command", cmd_ready_o, 1);
    cmd_valid_i = 1'b1; cmd_op_i = op[1:0]; cmd_sub_i = sub[2:0]; cmd_data_i = data;
    while (1) begin
      play_req_i  = (cyc < hold) || ($urandom_range(0, 99) < pct);
      play_addr_i = 17'($urandom);
      #1;
      if (play_req_i)
        chk(play_grant_o && mem_en_o && !mem_we_o && mem_addr_o == play_addr_i,
            "R8", "playout access", mem_addr_o, play_addr_i);
      else if (mem_en_o) begin
        nacc++;
        chk(mem_addr_o == m_ptr, (m_tog ? "R3" : "R4"), "host address", mem_addr_o, m_ptr);
        chk(mem_we_o == exp_we, "R7", "host write enable", mem_we_o, exp_we);
        if (exp_we) begin
          chk(mem_wdata_o == data, "R7", "write data", mem_wdata_o, data);
          exp_mem[int'(m_ptr)] = data;
        end else
          m_hreg = exp_mem.exists(int'(m_ptr)) ? exp_mem[int'(m_ptr)] : 16'd0;
        m_ptr = adv(m_ptr, m_tog);
      end
      if (cmd_done_o) break;
      if (cyc > 500) begin
        chk(1'b0, "R9", "command never completed", cyc, 0);
        break;
      end
      @(negedge clk_i);
      cmd_valid_i = 1'b0;
      cyc++;
    end
    cmd_valid_i = 1'b0;
    play_req_i = 1'b0;
    chk(cmd_ok_o == exp_ok, "R2", "ok flag", cmd_ok_o, exp_ok);
    chk(nacc == exp_acc, (op == 0) ? "R6" : "R5", "host access count", nacc, exp_acc);
    chk(cmd_ready_o == 1'b0, "R9", "stall at done", cmd_ready_o, 0);
    if (op == 1) chk(cmd_rdata_o == exp_rd, "R5", "prefetched read data", cmd_rdata_o, exp_rd);
    if (hold > 0) chk(cyc > hold, "R8", "host waited out playout", cyc, hold + 1);
    if (op == 0 && exp_acc == 0)
      chk(cyc == 1, exp_ok ? "R6" : "R2", "immediate completion", cyc, 1);
  endtask

  initial begin
    wait (cycles > 150000);
    chk(1'b0, "R9", "watchdog expired", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(cmd_ready_o == 1'b1 && cmd_done_o == 1'b0, "R1", "reset outputs",
        {cmd_ready_o, cmd_done_o}, 2'b10);
    chk(mem_en_o == 1'b0, "R1", "no access in reset", mem_en_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10/R1: data commands before any set-pointer
    run_cmd(1, 0, 16'h0, 0, 0);
    run_cmd(2, 0, 16'h1111, 0, 0);
    run_cmd(2, 0, 16'h2222, 0, 30);

    // R6/R7 32-bit write, R3/R5 32-bit read
    run_cmd(0, 3, 16'h0010, 0, 0);
    run_cmd(2, 0, 16'hA001, 0, 0);
    run_cmd(2, 0, 16'hA002, 0, 50);
    run_cmd(2, 0, 16'hA003, 0, 0);
    run_cmd(0, 0, 16'h0010, 0, 0);
    run_cmd(1, 0, 16'h0, 0, 0);
    run_cmd(1, 0, 16'h0, 0, 40);
    // R2 rejects leave state alone
    run_cmd(0, 1, 16'h7777, 0, 0);
    run_cmd(0, 6, 16'h7777, 0, 0);
    run_cmd(3, 0, 16'h7777, 0, 0);
    run_cmd(1, 0, 16'h0, 0, 0);

    // R4/R6 dual channels
    dual_mode_i = 1'b1;
    run_cmd(0, 0, 16'h5555, 0, 0);
    run_cmd(0, 4, 16'h0030, 0, 0);
    for (int i = 0; i < 3; i++) run_cmd(2, 0, 16'hC000 + 16'(i), 0, 20);
    run_cmd(0, 5, 16'h0030, 0, 0);
    for (int i = 0; i < 3; i++) run_cmd(2, 0, 16'hD000 + 16'(i), 0, 20);
    run_cmd(0, 1, 16'h0030, 0, 0);
    for (int i = 0; i < 3; i++) run_cmd(1, 0, 16'h0, 0, 30);
    run_cmd(0, 2, 16'h0030, 0, 0);
    for (int i = 0; i < 3; i++) run_cmd(1, 0, 16'h0, 0, 30);

    // R11 wrap in both policies
    run_cmd(0, 5, 16'hFFFF, 0, 0);
    run_cmd(2, 0, 16'hE001, 0, 0);
    run_cmd(2, 0, 16'hE002, 0, 0);
    dual_mode_i = 1'b0;
    run_cmd(0, 3, 16'hFFFF, 0, 0);
    for (int i = 0; i < 3; i++) run_cmd(2, 0, 16'hF000 + 16'(i), 0, 0);
    run_cmd(0, 0, 16'hFFFF, 0, 0);
    for (int i = 0; i < 3; i++) run_cmd(1, 0, 16'h0, 0, 0);

    // R8/R9 playout burst stalls the host
    run_cmd(2, 0, 16'hBEEF, 12, 0);
    run_cmd(1, 0, 16'h0, 9, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r, op, sub;
      if ($urandom_range(0, 19) == 0) dual_mode_i = ~dual_mode_i;
      r = $urandom_range(0, 99);
      op = (r < 25) ? 0 : (r < 60) ? 1 : (r < 95) ? 2 : 3;
      sub = $urandom_range(0, 7);
      run_cmd(op, sub,
              ($urandom_range(0, 9) == 0) ? 16'hFFFF : 16'($urandom_range(0, 7)),
              0, $urandom_range(0, 80));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule